// File: doc/BRIEF.md
# Bit-Interleaved Parity Striping Engine

The engine spreads each byte across eight data lanes, one bit per lane, where each lane stands for a separate storage device. A ninth lane carries a parity bit, so every write drives all nine lanes at once. On the read side, the engine takes the nine lane bits and a per-lane error flag. It returns the byte one cycle after the request.

One lane may be marked as failed. If that lane carries data, its bit is rebuilt from the eight other lanes. If the failed lane is the parity lane, the data bits are returned as they arrived. When more than one lane is flagged, the read is marked uncorrectable. When no lane is flagged but the nine lanes disagree with the parity, the data is still returned and a status bit reports the mismatch.

Top module: `bitstripe_engine`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `wr_ready`, `lane_wr_en`, `rd_valid`, `rd_uncorrectable` and `rd_parity_mismatch` are all 0.
- R2: One cycle after a write is accepted (`wr_valid` and `wr_ready` both high at a clock edge), `lane_wr_en` is 1 and `lane_wr_bits[i]` equals bit i of the written byte for i = 0..7.
- R3: Whenever `lane_wr_en` is 1, `lane_wr_bits[8]` holds even parity: the XOR of all nine lane bits is 0.
- R4: After reset, `wr_ready` stays at 1 and a write is accepted in every cycle. `lane_wr_en` is 0 in any cycle that does not follow an accepted write.
- R5: `rd_valid` is 1 exactly one cycle after `rd_req`. With no error flags and consistent parity, `rd_data` equals `lane_rd_bits[7:0]` sampled with the request.
- R6: With exactly one data lane i flagged in `lane_err`, `rd_data[i]` is the XOR of the other seven data lanes and lane 8. The other bits pass through, and both status outputs are 0.
- R7: With only lane 8 flagged, `rd_data` equals `lane_rd_bits[7:0]` and `rd_parity_mismatch` is 0, whatever lane 8 holds.
- R8: With two or more lanes flagged, `rd_uncorrectable` is 1, `rd_data` is 0 and `rd_parity_mismatch` is 0.
- R9: With no lane flagged and an odd XOR over the nine lanes, `rd_parity_mismatch` is 1 and `rd_data` equals `lane_rd_bits[7:0]`.
- R10: In a cycle where `rd_valid` is 0, `rd_uncorrectable` and `rd_parity_mismatch` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | A write byte is offered |
| wr_data | input | 8 | Byte to be striped |
| wr_ready | output | 1 | Engine accepts a byte this cycle |
| lane_wr_en | output | 1 | Lane write strobe for all nine lanes |
| lane_wr_bits | output | 9 | Bits driven to lanes 0..8; lane 8 is parity |
| rd_req | input | 1 | Read request; lane bits and flags sampled now |
| lane_rd_bits | input | 9 | Bits read back from lanes 0..8 |
| lane_err | input | 9 | Per-lane failure flags for this read |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 8 | Gathered or rebuilt byte |
| rd_uncorrectable | output | 1 | More than one lane flagged; data is invalid |
| rd_parity_mismatch | output | 1 | Clean read whose lanes fail the parity check |

## Verification
Every cycle, the assertions check four properties: the write lane map against the byte that was accepted, even parity on every lane write, the one-cycle read latency, and the rules that tie the status outputs to `rd_valid` and to zeroed data. The scoreboard scenarios cover the rest: reconstruction of each data lane in turn, data passing unchanged when the parity lane is lost, single-bit corruption producing a mismatch status, double and total flag sets, and writes and reads issued in the same cycle. They also confirm that the outputs stay quiet in idle gaps.

// File: rtl/bitstripe_pkg.sv
package bitstripe_pkg;

    // Classification of a read after the flags and parity are examined.
    typedef enum logic [2:0] {
        RD_CLEAN       = 3'd0,
        RD_REPAIRED    = 3'd1,
        RD_PARITY_LOST = 3'd2,
        RD_MISMATCH    = 3'd3,
        RD_FATAL       = 3'd4
    } rd_outcome_e;

endpackage

// File: rtl/stripe_encoder.sv
module stripe_encoder #(
    parameter int unsigned DATA_LANES = 8
) (
    input  logic [DATA_LANES-1:0] byte_in,
    output logic [DATA_LANES:0]   lanes_out
);
    // Fixed map: bit g goes to lane g; the top lane carries even parity.
    for (genvar g = 0; g < DATA_LANES; g++) begin : g_map
        assign lanes_out[g] = byte_in[g];
    end
    assign lanes_out[DATA_LANES] = ^byte_in;
endmodule

// File: rtl/lane_rebuilder.sv
module lane_rebuilder
    import bitstripe_pkg::*;
#(
    parameter int unsigned DATA_LANES = 8
) (
    input  logic [DATA_LANES:0]   lanes_in,
    input  logic [DATA_LANES:0]   flags_in,
    output logic [DATA_LANES-1:0] byte_out,
    output rd_outcome_e           outcome
);
    localparam int unsigned ALL_LANES = DATA_LANES + 1;
    localparam int unsigned CNT_W     = $clog2(ALL_LANES + 1);

    logic                  all_xor;
    logic [CNT_W-1:0]      flag_cnt;
    logic [DATA_LANES-1:0] fixed;

    assign all_xor = ^lanes_in;

    always_comb begin
        flag_cnt = '0;
        for (int i = 0; i < ALL_LANES; i++) begin
            flag_cnt = flag_cnt + CNT_W'(flags_in[i]);
        end
    end

    // XOR of every other lane equals the full XOR with this lane removed.
    for (genvar g = 0; g < DATA_LANES; g++) begin : g_fix
        assign fixed[g] = flags_in[g] ? (all_xor ^ lanes_in[g]) : lanes_in[g];
    end

    always_comb begin
        if (flag_cnt == '0) begin
            outcome = all_xor ? RD_MISMATCH : RD_CLEAN;
        end else if (flag_cnt == CNT_W'(1)) begin
            outcome = flags_in[DATA_LANES] ? RD_PARITY_LOST : RD_REPAIRED;
        end else begin
            outcome = RD_FATAL;
        end
        byte_out = (outcome == RD_FATAL) ? '0 : fixed;
    end
endmodule

// File: rtl/bitstripe_engine.sv
module bitstripe_engine
    import bitstripe_pkg::*;
#(
    parameter int unsigned DATA_LANES = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_valid,
    input  logic [DATA_LANES-1:0] wr_data,
    output logic                  wr_ready,
    output logic                  lane_wr_en,
    output logic [DATA_LANES:0]   lane_wr_bits,
    input  logic                  rd_req,
    input  logic [DATA_LANES:0]   lane_rd_bits,
    input  logic [DATA_LANES:0]   lane_err,
    output logic                  rd_valid,
    output logic [DATA_LANES-1:0] rd_data,
    output logic                  rd_uncorrectable,
    output logic                  rd_parity_mismatch
);
    localparam int unsigned ALL_LANES = DATA_LANES + 1;

    typedef struct packed {
        logic                  wr_ready;
        logic                  lwr_en;
        logic [ALL_LANES-1:0]  lwr_bits;
        logic                  rd_valid;
        logic [DATA_LANES-1:0] rd_data;
        logic                  rd_fatal;
        logic                  rd_mism;
    } eng_state_t;

    eng_state_t q, d;

    logic [ALL_LANES-1:0]  enc_lanes;
    logic [DATA_LANES-1:0] rb_byte;
    rd_outcome_e           rb_outcome;

    stripe_encoder #(.DATA_LANES(DATA_LANES)) u_enc (
        .byte_in   (wr_data),
        .lanes_out (enc_lanes)
    );

    lane_rebuilder #(.DATA_LANES(DATA_LANES)) u_rb (
        .lanes_in (lane_rd_bits),
        .flags_in (lane_err),
        .byte_out (rb_byte),
        .outcome  (rb_outcome)
    );

    always_comb begin
        d          = q;
        d.wr_ready = 1'b1;
        d.lwr_en   = wr_valid && q.wr_ready;
        if (wr_valid && q.wr_ready) begin
            d.lwr_bits = enc_lanes;
        end
        d.rd_valid = rd_req;
        if (rd_req) begin
            d.rd_data  = rb_byte;
            d.rd_fatal = (rb_outcome == RD_FATAL);
            d.rd_mism  = (rb_outcome == RD_MISMATCH);
        end else begin
            d.rd_fatal = 1'b0;
            d.rd_mism  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign wr_ready           = q.wr_ready;
    assign lane_wr_en         = q.lwr_en;
    assign lane_wr_bits       = q.lwr_bits;
    assign rd_valid           = q.rd_valid;
    assign rd_data            = q.rd_data;
    assign rd_uncorrectable   = q.rd_fatal;
    assign rd_parity_mismatch = q.rd_mism;

    // R2: the lanes carry the byte accepted in the previous cycle.
    p_lane_map_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_valid && wr_ready) |->
            (lane_wr_en && lane_wr_bits[DATA_LANES-1:0] == $past(wr_data)));

    // R3: every lane write has even parity across all lanes.
    p_even_parity_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lane_wr_en |-> (^lane_wr_bits == 1'b0));

    // R5: a read request yields a result in the next cycle.
    p_rd_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid);

    // R8: an uncorrectable read returns zero data and no mismatch.
    p_fatal_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_uncorrectable |-> (rd_data == '0 && !rd_parity_mismatch));

    // R10: status outputs are quiet unless a result is valid.
    p_status_qual_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (!rd_uncorrectable && !rd_parity_mismatch));
endmodule

// File: tb/bitstripe_engine_tb_top.sv
module bitstripe_engine_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = '0;
    logic       wr_ready;
    logic       lane_wr_en;
    logic [8:0] lane_wr_bits;
    logic       rd_req = 1'b0;
    logic [8:0] lane_rd_bits = '0;
    logic [8:0] lane_err = '0;
    logic       rd_valid;
    logic [7:0] rd_data;
    logic       rd_uncorrectable;
    logic       rd_parity_mismatch;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    bit running = 1'b0;
    bit done = 1'b0;

    typedef struct {
        int         due;
        logic [8:0] lanes;
    } wr_item_t;

    typedef struct {
        int         due;
        logic [7:0] data;
        bit         unc;
        bit         mis;
        string      req;
    } rd_item_t;

    wr_item_t wq[$];
    rd_item_t rq[$];

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    bitstripe_engine dut_i (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
        .lane_wr_en(lane_wr_en), .lane_wr_bits(lane_wr_bits),
        .rd_req(rd_req), .lane_rd_bits(lane_rd_bits), .lane_err(lane_err),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .rd_uncorrectable(rd_uncorrectable), .rd_parity_mismatch(rd_parity_mismatch)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic logic [8:0] enc(input logic [7:0] b);
        return {^b, b};
    endfunction

    // Independent model of the read rules R5..R9.
    task automatic model_read(input logic [8:0] ln, input logic [8:0] er,
                              output logic [7:0] dat, output bit unc, output bit mis);
        int   n;
        logic p;
        n = 0;
        for (int i = 0; i < 9; i++) n += int'(er[i]);
        dat = ln[7:0];
        unc = 1'b0;
        mis = 1'b0;
        if (n >= 2) begin
            unc = 1'b1;
            dat = '0;
        end else if (n == 1) begin
            for (int i = 0; i < 8; i++) begin
                if (er[i]) begin
                    p = ln[8];
                    for (int j = 0; j < 8; j++) if (j != i) p = p ^ ln[j];
                    dat[i] = p;
                end
            end
        end else begin
            mis = ^ln;
        end
    endtask

    // Driver: one cycle of stimulus, expected results pushed to the scoreboard.
    task automatic step(input bit dw, input logic [7:0] wb, input bit dr,
                        input logic [8:0] ln, input logic [8:0] er, input string req);
        wr_item_t wi;
        rd_item_t ri;
        @(posedge clk);
        #1;
        wr_valid     = dw;
        wr_data      = wb;
        rd_req       = dr;
        lane_rd_bits = ln;
        lane_err     = er;
        if (dw) begin
            wi.due   = cyc + 1;
            wi.lanes = enc(wb);
            wq.push_back(wi);
        end
        if (dr) begin
            ri.due = cyc + 1;
            ri.req = req;
            model_read(ln, er, ri.data, ri.unc, ri.mis);
            rq.push_back(ri);
        end
    endtask

    task automatic idle();
        step(1'b0, 8'h00, 1'b0, 9'h000, 9'h000, "");
    endtask

    task automatic rd(input logic [8:0] ln, input logic [8:0] er, input string req);
        step(1'b0, 8'h00, 1'b1, ln, er, req);
    endtask

    // Monitor: compare outputs with the scoreboard away from the active edge.
    always @(negedge clk) begin
        if (running) begin
            if (wq.size() > 0 && wq[0].due == cyc) begin
                check(lane_wr_en == 1'b1, "R4 write strobe", 32'(lane_wr_en), 32'd1);
                check(lane_wr_bits[7:0] == wq[0].lanes[7:0], "R2 lane map",
                      32'(lane_wr_bits[7:0]), 32'(wq[0].lanes[7:0]));
                check(lane_wr_bits[8] == wq[0].lanes[8], "R3 parity lane",
                      32'(lane_wr_bits[8]), 32'(wq[0].lanes[8]));
                void'(wq.pop_front());
            end else begin
                check(lane_wr_en == 1'b0, "R4 no spurious write", 32'(lane_wr_en), 32'd0);
            end
            if (rq.size() > 0 && rq[0].due == cyc) begin
                check(rd_valid == 1'b1, "R5 read latency", 32'(rd_valid), 32'd1);
                check(rd_data == rq[0].data, rq[0].req, 32'(rd_data), 32'(rq[0].data));
                check(rd_uncorrectable == rq[0].unc, {rq[0].req, " uncorrectable"},
                      32'(rd_uncorrectable), 32'(rq[0].unc));
                check(rd_parity_mismatch == rq[0].mis, {rq[0].req, " mismatch"},
                      32'(rd_parity_mismatch), 32'(rq[0].mis));
                void'(rq.pop_front());
            end else begin
                check(rd_valid == 1'b0 && rd_uncorrectable == 1'b0 && rd_parity_mismatch == 1'b0,
                      "R10 quiet when not valid",
                      {29'd0, rd_valid, rd_uncorrectable, rd_parity_mismatch}, 32'd0);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #400000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired (cycle %0d)", cyc);
        finish_run();
    end

    initial begin
        logic [8:0] ln;
        // R1: outputs during reset
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(wr_ready == 1'b0 && lane_wr_en == 1'b0 && rd_valid == 1'b0 &&
              rd_uncorrectable == 1'b0 && rd_parity_mismatch == 1'b0, "R1 reset state",
              {27'd0, wr_ready, lane_wr_en, rd_valid, rd_uncorrectable, rd_parity_mismatch}, 32'd0);
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        check(wr_ready == 1'b0 && lane_wr_en == 1'b0 && rd_valid == 1'b0,
              "R1 first cycle after reset", {29'd0, wr_ready, lane_wr_en, rd_valid}, 32'd0);
        @(negedge clk);
        check(wr_ready == 1'b1, "R4 ready after reset", 32'(wr_ready), 32'd1);
        running = 1'b1;

        // R2 R3 R4: corner bytes back to back, then a computed series
        step(1'b1, 8'h00, 1'b0, '0, '0, "");
        step(1'b1, 8'hFF, 1'b0, '0, '0, "");
        step(1'b1, 8'hA5, 1'b0, '0, '0, "");
        step(1'b1, 8'h01, 1'b0, '0, '0, "");
        step(1'b1, 8'h80, 1'b0, '0, '0, "");
        idle();
        for (int i = 0; i < 16; i++) step(1'b1, 8'(i * 29 + 3), 1'b0, '0, '0, "");
        idle();
        idle();

        // R5: clean reads of consistent lanes
        rd(enc(8'h00), 9'h000, "R5 clean read");
        rd(enc(8'hFF), 9'h000, "R5 clean read");
        rd(enc(8'h3C), 9'h000, "R5 clean read");
        idle();

        // R6: each data lane lost in turn, its bit corrupted
        for (int i = 0; i < 8; i++) begin
            ln = enc(8'h5C);
            ln[i] = ~ln[i];
            rd(ln, 9'(1) << i, "R6 rebuild data lane");
        end
        for (int i = 0; i < 8; i++) rd(enc(8'hC3), 9'(1) << i, "R6 rebuild intact lane");

        // R7: parity lane lost, parity value wrong or right
        ln = enc(8'h96);
        ln[8] = ~ln[8];
        rd(ln, 9'h100, "R7 parity lane lost");
        rd(enc(8'h96), 9'h100, "R7 parity lane lost");

        // R8: two flags, and every flag
        rd(enc(8'h7E), 9'h042, "R8 two lanes flagged");
        rd(enc(8'h7E), 9'h1FF, "R8 all lanes flagged");
        rd(enc(8'h11), 9'h101, "R8 data and parity flagged");
        idle();

        // R9: clean flags but a flipped bit
        ln = enc(8'h24);
        ln[3] = ~ln[3];
        rd(ln, 9'h000, "R9 parity mismatch");
        ln = enc(8'h24);
        ln[8] = ~ln[8];
        rd(ln, 9'h000, "R9 parity mismatch on parity lane");

        // Concurrent write and read
        step(1'b1, 8'hE7, 1'b1, enc(8'hB2), 9'h000, "R5 read with write");
        step(1'b1, 8'h18, 1'b1, enc(8'hB2), 9'h020, "R6 read with write");
        idle();
        idle();
        idle();
        running = 1'b0;
        check(wq.size() == 0, "R4 write queue drained", 32'(wq.size()), 32'd0);
        check(rq.size() == 0, "R5 read queue drained", 32'(rq.size()), 32'd0);
        finish_run();
    end
endmodule